// File: doc/BRIEF.md
# Fully Associative Translation Buffer

This block holds a small, fully associative table of address translations. Each slot pairs a high word with a low word. The high word carries a 20-bit virtual page number and a 6-bit address-space identifier. The low word carries a 20-bit page frame number and the no-cache, dirty, valid and global flags. Software loads a staging high register, a staging low register and a slot register, then commits the staged pair into a table slot. The slot is either the one named by the slot register or the one named by a free-running rotating pointer. A search operation looks up the staged high word and reports the slot it finds through the slot register.

Load and store addresses are looked up in one cycle. The result appears on the registered outputs in the following cycle. A hit returns the physical address. A miss or protection failure returns a fault code and a class bit. The class bit tells the exception logic whether the fast miss handler applies: it does only for a plain no-match in the user half of the address space. A match that is invalid, or a store to a clean page, always goes to the general class. When several slots match, the lowest-numbered one is used.

Top module: `tlb_lookup`

## Requirements
- R1: A slot matches a lookup when its page number equals address bits 31..12 and its identifier equals bits 11..6 of the staging high register. With the global flag clear, a differing identifier is a miss.
- R2: When a slot's global flag is set, the slot matches on the page number alone. The global flag is low word bit 8.
- R3: A lookup presented in one cycle gives its result in the next cycle with `res_valid` high. On a hit, `res_hit` is 1, `res_fault` is 0, `res_refill` is 0, and `res_paddr` is the frame number (low word bits 31..12) joined with address bits 11..0.
- R4: A matching slot with the valid flag (low word bit 9) clear gives `res_fault` = 1 for a load or 2 for a store, with `res_refill` = 0.
- R5: A store that matches a valid slot whose dirty flag (low word bit 10) is clear gives `res_fault` = 3 with `res_refill` = 0. A load to the same slot hits.
- R6: With no matching slot, `res_fault` is 1 for a load and 2 for a store. `res_refill` is 1 when address bit 31 is 0, and 0 when address bit 31 is 1.
- R7: A search (`op_code` = 3) that finds the staged high word sets `index_q` to the slot number shifted left by 8, with bit 31 clear. A search that finds nothing sets `index_q` bit 31 and leaves the other bits unchanged.
- R8: `op_code` = 1 copies the staging high and low registers into the slot given by `index_q` bits 13..8. `op_code` = 2 copies them into the slot shown on `random_q` in that cycle.
- R9: `random_q` is 63 after reset and steps down by one every cycle. After 8 it returns to 63, so it never shows a value below 8.
- R10: When more than one slot matches, a lookup or search uses the lowest-numbered matching slot.
- R11: After reset, `res_valid` and `index_q` are 0, and every slot holds page 0, identifier 0 and all flags clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hi_we | input | 1 | Load `reg_wdata` into the staging high register |
| lo_we | input | 1 | Load `reg_wdata` into the staging low register |
| idx_we | input | 1 | Load `reg_wdata` into the slot register |
| reg_wdata | input | 32 | Register write data |
| op_valid | input | 1 | Table operation strobe |
| op_code | input | 2 | 1 = write at slot register, 2 = write at rotating pointer, 3 = search |
| xl_valid | input | 1 | Lookup request |
| xl_store | input | 1 | Lookup is a store |
| xl_vaddr | input | 32 | Virtual address to translate |
| res_valid | output | 1 | Lookup result present |
| res_hit | output | 1 | Translation succeeded |
| res_paddr | output | 32 | Physical address on a hit |
| res_fault | output | 2 | 0 none, 1 load fault, 2 store fault, 3 modify fault |
| res_refill | output | 1 | Fault belongs to the fast miss class |
| hi_q | output | 32 | Staging high register |
| lo_q | output | 32 | Staging low register |
| index_q | output | 32 | Slot register |
| random_q | output | 6 | Rotating write pointer |

## Verification
A corrupted slot, a wrong identifier compare or a broken priority encoder shows up on the first lookup that touches the affected page. It appears one cycle later as a wrong frame number, a wrong fault code or a flipped class bit. A misplaced write becomes visible on the next search, because the slot register then reports a different slot number. A pointer that drifts out of its range, or skips a value, is visible on `random_q` within one rotation of 56 cycles. Each of these faults is seen by a directed check before the bench moves on.

// File: rtl/tlb_lookup.sv
module tlb_lookup #(
  parameter int ENTRIES = 64,
  parameter int WIRED   = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         hi_we,
  input  logic                         lo_we,
  input  logic                         idx_we,
  input  logic [31:0]                  reg_wdata,
  input  logic                         op_valid,
  input  logic [1:0]                   op_code,
  input  logic                         xl_valid,
  input  logic                         xl_store,
  input  logic [31:0]                  xl_vaddr,
  output logic                         res_valid,
  output logic                         res_hit,
  output logic [31:0]                  res_paddr,
  output logic [1:0]                   res_fault,
  output logic                         res_refill,
  output logic [31:0]                  hi_q,
  output logic [31:0]                  lo_q,
  output logic [31:0]                  index_q,
  output logic [$clog2(ENTRIES)-1:0]   random_q
);
  localparam int IW = $clog2(ENTRIES);
  localparam logic [1:0] OP_WIDX = 2'd1, OP_WRND = 2'd2, OP_PROBE = 2'd3;
  localparam logic [1:0] F_NONE = 2'd0, F_LOAD = 2'd1, F_STORE = 2'd2, F_MOD = 2'd3;

  logic [25:0] ent_hi [ENTRIES];
  logic [22:0] ent_lo [ENTRIES];

  logic [ENTRIES-1:0] xl_match, pr_match;
  logic               xl_any, pr_any;
  logic [IW-1:0]      xl_idx, pr_idx;
  logic [22:0]        sel_lo;
  logic               hit_c, refill_c;
  logic [1:0]         fault_c;

  wire            do_write = op_valid && (op_code == OP_WIDX || op_code == OP_WRND);
  wire            do_probe = op_valid && op_code == OP_PROBE;
  wire [IW-1:0]   wr_slot  = (op_code == OP_WIDX) ? index_q[IW+7:8] : random_q;
  wire [5:0]      cur_asid = hi_q[11:6];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    wire glob    = ent_lo[g][0];
    wire asid_ok = glob || ent_hi[g][5:0] == cur_asid;
    assign xl_match[g] = asid_ok && ent_hi[g][25:6] == xl_vaddr[31:12];
    assign pr_match[g] = asid_ok && ent_hi[g][25:6] == hi_q[31:12];
  end

  always_comb begin
    xl_any = 1'b0; xl_idx = '0;
    pr_any = 1'b0; pr_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (xl_match[i]) begin xl_any = 1'b1; xl_idx = IW'(i); end
      if (pr_match[i]) begin pr_any = 1'b1; pr_idx = IW'(i); end
    end
  end

  assign sel_lo = ent_lo[xl_idx];

  always_comb begin
    hit_c    = 1'b0;
    refill_c = 1'b0;
    fault_c  = xl_store ? F_STORE : F_LOAD;
    if (!xl_any)
      refill_c = !xl_vaddr[31];
    else if (!sel_lo[1])
      refill_c = 1'b0;
    else if (xl_store && !sel_lo[2])
      fault_c = F_MOD;
    else begin
      hit_c   = 1'b1;
      fault_c = F_NONE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) begin
        ent_hi[i] <= '0;
        ent_lo[i] <= '0;
      end
    end else if (do_write) begin
      for (int i = 0; i < ENTRIES; i++)
        if (wr_slot == IW'(i)) begin
          ent_hi[i] <= hi_q[31:6];
          ent_lo[i] <= {lo_q[31:12], lo_q[10:8]};
        end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_q    <= '0;
      lo_q    <= '0;
      index_q <= '0;
    end else begin
      if (hi_we) hi_q <= reg_wdata;
      if (lo_we) lo_q <= reg_wdata;
      if (idx_we)
        index_q <= reg_wdata;
      else if (do_probe) begin
        if (pr_any) index_q <= 32'(pr_idx) << 8;
        else        index_q[31] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      random_q <= IW'(ENTRIES - 1);
    else if (random_q == IW'(WIRED))
      random_q <= IW'(ENTRIES - 1);
    else
      random_q <= random_q - IW'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid  <= 1'b0;
      res_hit    <= 1'b0;
      res_paddr  <= '0;
      res_fault  <= F_NONE;
      res_refill <= 1'b0;
    end else begin
      res_valid <= xl_valid;
      if (xl_valid) begin
        res_hit    <= hit_c;
        res_paddr  <= {sel_lo[22:3], xl_vaddr[11:0]};
        res_fault  <= fault_c;
        res_refill <= refill_c;
      end
    end
  end

  a_r9_random_range: assert property (@(posedge clk) disable iff (!rst_n)
    random_q >= IW'(WIRED) && random_q <= IW'(ENTRIES - 1));
  a_r9_random_moves: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> !$stable(random_q));
  a_r3_hit_clean: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_hit |-> res_fault == F_NONE && !res_refill);
  a_r3_offset: assert property (@(posedge clk) disable iff (!rst_n)
    xl_valid |=> !res_hit || res_paddr[11:0] == $past(xl_vaddr[11:0]));
  a_r6_refill_miss: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_refill |-> !res_hit && (res_fault == F_LOAD || res_fault == F_STORE));
  a_r6_kernel_general: assert property (@(posedge clk) disable iff (!rst_n)
    xl_valid && xl_vaddr[31] |=> !res_refill);
  a_r5_mod_only_store: assert property (@(posedge clk) disable iff (!rst_n)
    xl_valid && !xl_store |=> res_fault != F_MOD);
  a_r7_probe_form: assert property (@(posedge clk) disable iff (!rst_n)
    do_probe && !idx_we |=> index_q[31] || index_q[7:0] == 8'd0);
endmodule

// File: tb/tlb_lookup_test.sv
module tlb_lookup_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hi_we = 0, lo_we = 0, idx_we = 0;
  logic [31:0] reg_wdata = '0;
  logic        op_valid = 0;
  logic [1:0]  op_code = '0;
  logic        xl_valid = 0, xl_store = 0;
  logic [31:0] xl_vaddr = '0;
  logic        res_valid, res_hit, res_refill;
  logic [31:0] res_paddr, hi_q, lo_q, index_q;
  logic [1:0]  res_fault;
  logic [5:0]  random_q;

  int checks = 0, fails = 0;

  tlb_lookup uut (.*);

  always #10 clk = ~clk;

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_hi(input logic [19:0] vpn, input logic [5:0] asid);
    return {vpn, asid, 6'b0};
  endfunction

  function automatic logic [31:0] mk_lo(input logic [19:0] pfn, input bit d, input bit v, input bit g);
    return {pfn, 1'b0, d, v, g, 8'b0};
  endfunction

  task automatic wreg(input int which, input logic [31:0] d);
    hi_we = (which == 0); lo_we = (which == 1); idx_we = (which == 2);
    reg_wdata = d;
    @(negedge clk);
    hi_we = 0; lo_we = 0; idx_we = 0;
  endtask

  task automatic do_op(input logic [1:0] c);
    op_valid = 1; op_code = c;
    @(negedge clk);
    op_valid = 0; op_code = '0;
  endtask

  task automatic put_idx(input int slot, input logic [31:0] h, input logic [31:0] l);
    wreg(2, 32'(slot) << 8);
    wreg(0, h);
    wreg(1, l);
    do_op(2'd1);
  endtask

  task automatic xlate(input logic [31:0] va, input bit st);
    xl_valid = 1; xl_store = st; xl_vaddr = va;
    @(negedge clk);
    xl_valid = 0; xl_store = 0;
  endtask

  // {vaddr, store, hit, paddr, fault, refill}
  localparam logic [68:0] VEC [11] = '{
    {32'h00400abc, 1'b0, 1'b1, 32'h12345abc, 2'd0, 1'b0}, // R3 R10
    {32'h00400001, 1'b1, 1'b1, 32'h12345001, 2'd0, 1'b0}, // R3
    {32'h00401ff0, 1'b0, 1'b1, 32'h11111ff0, 2'd0, 1'b0}, // R2 R5
    {32'h00401000, 1'b1, 1'b0, 32'h0,        2'd3, 1'b0}, // R5
    {32'h00402000, 1'b0, 1'b0, 32'h0,        2'd1, 1'b0}, // R4
    {32'h00402000, 1'b1, 1'b0, 32'h0,        2'd2, 1'b0}, // R4
    {32'h00403000, 1'b0, 1'b0, 32'h0,        2'd1, 1'b1}, // R1
    {32'h00500000, 1'b1, 1'b0, 32'h0,        2'd2, 1'b1}, // R6
    {32'h80010123, 1'b0, 1'b1, 32'h33333123, 2'd0, 1'b0}, // R1 R3
    {32'h80020000, 1'b0, 1'b0, 32'h0,        2'd1, 1'b0}, // R6
    {32'hc0000000, 1'b1, 1'b0, 32'h0,        2'd2, 1'b0}  // R6
  };

  bit done = 0;

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    check(res_valid == 0 && index_q == 0, "R11 reset outputs", {res_valid, index_q}, 0);
    rst_n = 1;
    // R9 rotation
    begin
      int exp_r = 63;
      bit ok = 1;
      for (int c = 0; c < 130; c++) begin
        if (random_q != 6'(exp_r)) ok = 0;
        if (c < 2) check(random_q == 6'(exp_r), "R9 pointer start", random_q, exp_r);
        @(negedge clk);
        exp_r = (exp_r == 8) ? 63 : exp_r - 1;
      end
      check(ok, "R9 pointer sequence", random_q, exp_r);
    end
    // R11 empty table: page 5 misses in user space
    xlate(32'h00005000, 0);
    check(res_valid && !res_hit && res_fault == 1 && res_refill, "R11 empty table miss",
          {res_valid, res_hit, res_fault, res_refill}, {1'b1, 1'b0, 2'd1, 1'b1});

    // R8 indexed writes
    put_idx(0, mk_hi(20'h00400, 6'd5), mk_lo(20'h12345, 1, 1, 0));
    put_idx(1, mk_hi(20'h00401, 6'd9), mk_lo(20'h11111, 0, 1, 1));
    put_idx(2, mk_hi(20'h00402, 6'd5), mk_lo(20'h0abcd, 1, 0, 0));
    put_idx(3, mk_hi(20'h00403, 6'd7), mk_lo(20'h22222, 1, 1, 0));
    put_idx(4, mk_hi(20'h80010, 6'd5), mk_lo(20'h33333, 1, 1, 0));
    put_idx(5, mk_hi(20'h00400, 6'd5), mk_lo(20'h44444, 1, 1, 0));
    wreg(0, mk_hi(20'h0, 6'd5));

    for (int i = 0; i < 11; i++) begin
      logic [68:0] v = VEC[i];
      xlate(v[68:37], v[36]);
      check(res_valid && res_hit == v[35] && res_fault == v[2:1] && res_refill == v[0]
            && (!v[35] || res_paddr == v[34:3]),
            $sformatf("vector %0d", i),
            {res_hit, res_paddr, res_fault, res_refill}, {v[35], v[34:3], v[2:1], v[0]});
    end

    // R7 search hit on slot 3
    wreg(0, mk_hi(20'h00403, 6'd7));
    do_op(2'd3);
    check(index_q == 32'h00000300, "R7 search hit", index_q, 32'h300);
    // R7 search miss keeps low bits, sets bit 31
    wreg(0, mk_hi(20'h77777, 6'd7));
    do_op(2'd3);
    check(index_q == 32'h80000300, "R7 search miss", index_q, 32'h80000300);
    // R2 search of a global slot with another identifier
    wreg(0, mk_hi(20'h00401, 6'd33));
    do_op(2'd3);
    check(index_q == 32'h00000100, "R2 global search", index_q, 32'h100);
    // R10 search picks lowest of slots 0 and 5
    wreg(0, mk_hi(20'h00400, 6'd5));
    do_op(2'd3);
    check(index_q == 32'h00000000, "R10 lowest slot search", index_q, 0);
    // R1 identifier mismatch on non-global slot 3
    wreg(0, mk_hi(20'h00403, 6'd5));
    do_op(2'd3);
    check(index_q[31] == 1'b1, "R1 identifier mismatch search", index_q, 32'h80000000);

    // R8 rotating write lands on the slot shown by random_q
    begin
      logic [5:0] rslot;
      wreg(0, mk_hi(20'h00600, 6'd5));
      wreg(1, mk_lo(20'h55555, 1, 1, 0));
      rslot = random_q;
      do_op(2'd2);
      check(rslot >= 8, "R9 pointer above wired", rslot, 8);
      xlate(32'h00600444, 1);
      check(res_hit && res_paddr == 32'h55555444, "R8 rotating write lookup", res_paddr, 32'h55555444);
      do_op(2'd3);
      check(index_q == 32'(rslot) << 8, "R8 rotating write slot", index_q, 32'(rslot) << 8);
    end

    // R8 overwrite slot 0 through the slot register; slot 5 now wins
    put_idx(0, mk_hi(20'h00900, 6'd5), mk_lo(20'h66666, 1, 1, 0));
    xlate(32'h00400010, 0);
    check(res_hit && res_paddr == 32'h44444010, "R10 next matching slot", res_paddr, 32'h44444010);
    xlate(32'h00900010, 0);
    check(res_hit && res_paddr == 32'h66666010, "R8 indexed overwrite", res_paddr, 32'h66666010);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule